// File: doc/BRIEF.md
# Grayscale Pixel Remap and Display Mode Stage

This stage sits between the read port of a display RAM and the column driver. A scan sequencer gives it a logical scan row and a column address. The stage returns at once the physical RAM row and column to fetch. The RAM answers in the same cycle with a byte that packs two 4-bit gray pixels. One clock later the stage presents the two gray levels to drive, the common-line (COM) index they belong to, and a drive enable.

The row address is the scan row scrolled by a start line. The COM index is the scan row shifted by an offset, optionally reversed, and optionally split into odd and even halves. The column address can be mirrored. The two nibbles of the byte can be exchanged. A global display mode is applied last: it either passes the data, forces full white, forces black, or inverts every level. A sleep control blanks everything.

Top module: `gsr_top`

## Requirements
- R1: `fetch_row` equals (`scan_row` + `start_line`) mod 128 in the same cycle, with no register on the path.
- R2: `fetch_col` equals `scan_col` when `col_rev` is 0 and 63 − `scan_col` when `col_rev` is 1, combinationally.
- R3: With `nib_swap` = 0, `pix_left` takes `ram_byte[7:4]` and `pix_right` takes `ram_byte[3:0]`. With `nib_swap` = 1 the two nibbles trade places. The result appears one clock after the byte is presented.
- R4: On each clock with `scan_vld` = 1, `com_idx` is loaded with c = (`scan_row` + `com_offset`) mod 128, or with 127 − c when `com_rev` = 1.
- R5: When `com_split` = 1, the index from R4 is rotated left by one bit within 7 bits, {c[5:0], c[6]}, before it is loaded. Indices below 64 therefore land on even lines and the rest land on odd lines.
- R6: `drive_en` is 1 one clock after a cycle with `scan_vld` = 1, `scan_row` ≤ `mux_ratio` and `sleep_en` = 0. In every other case it is 0. When `drive_en` is 0, both pixel outputs are 0.
- R7: `disp_mode` = 2'b01 forces both pixels to 15, whatever the RAM byte holds.
- R8: `disp_mode` = 2'b10 forces both pixels to 0, whatever the RAM byte holds.
- R9: `disp_mode` = 2'b11 replaces each gray level g, taken after the nibble swap, by 15 − g. `disp_mode` = 2'b00 passes the level unchanged.
- R10: A cycle with `sleep_en` = 1 gives `drive_en` = 0 and zero pixels on the next clock. Once `sleep_en` returns to 0, driving resumes on the following clock.
- R11: Synchronous reset clears `drive_en`, `com_idx`, `pix_left` and `pix_right` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_vld | input | 1 | Scan row and RAM byte are valid this cycle |
| scan_row | input | 7 | Logical scan row |
| scan_col | input | 6 | Logical column address |
| ram_byte | input | 8 | RAM byte holding two gray pixels |
| col_rev | input | 1 | Mirror the column address |
| nib_swap | input | 1 | Exchange the two nibbles |
| com_rev | input | 1 | Reverse the COM index |
| com_split | input | 1 | Odd/even COM interleave |
| start_line | input | 7 | RAM row shown on scan row 0 |
| com_offset | input | 7 | COM shift |
| mux_ratio | input | 7 | Last scan row driven (active rows minus one) |
| disp_mode | input | 2 | 00 normal, 01 all on, 10 all off, 11 inverse |
| sleep_en | input | 1 | Blank the outputs |
| fetch_row | output | 7 | RAM row to read |
| fetch_col | output | 6 | RAM column to read |
| com_idx | output | 7 | Physical COM line of the pixels now driven |
| drive_en | output | 1 | Pixels are to be driven |
| pix_left | output | 4 | Gray level of the left pixel |
| pix_right | output | 4 | Gray level of the right pixel |

## Verification
The only state in the block is the output register. A wrong value there shows up at the ports exactly one clock after the stimulus that produced it. A wrong gating term would show as a pixel pair that stays lit past the MUX limit or during sleep, and that error is visible on that same following clock. Errors in the address arithmetic stay visible for the whole cycle on `fetch_row` and `fetch_col`. The bench crosses wrap points of the scroll and offset sums and the split of both halves of the COM range. It also covers every display mode in combination with nibble swapping.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'b00,
        MODE_ALL_ON  = 2'b01,
        MODE_ALL_OFF = 2'b10,
        MODE_INVERT  = 2'b11
    } disp_mode_e;

    typedef struct packed {
        logic col_rev;
        logic nib_swap;
        logic com_rev;
        logic com_split;
    } remap_t;

    function automatic logic [3:0] mode_apply(input logic [3:0] g, input disp_mode_e m);
        case (m)
            MODE_ALL_ON:  mode_apply = 4'hF;
            MODE_ALL_OFF: mode_apply = 4'h0;
            MODE_INVERT:  mode_apply = ~g;
            default:      mode_apply = g;
        endcase
    endfunction

endpackage

// File: rtl/gsr_row_map.sv
module gsr_row_map #(
    parameter int ROW_W = 7
) (
    input  logic [ROW_W-1:0] scan_row,
    input  logic [ROW_W-1:0] start_line,
    input  logic [ROW_W-1:0] com_offset,
    input  logic             com_rev,
    input  logic             com_split,
    output logic [ROW_W-1:0] fetch_row,
    output logic [ROW_W-1:0] com_next
);
    logic [ROW_W-1:0] shifted;
    logic [ROW_W-1:0] flipped;

    always_comb begin
        fetch_row = scan_row + start_line;
        shifted   = scan_row + com_offset;
        flipped   = com_rev ? ~shifted : shifted;
        com_next  = com_split ? {flipped[ROW_W-2:0], flipped[ROW_W-1]} : flipped;
    end
endmodule

// File: rtl/gsr_col_map.sv
module gsr_col_map #(
    parameter int COL_W = 6
) (
    input  logic [COL_W-1:0] scan_col,
    input  logic             col_rev,
    output logic [COL_W-1:0] fetch_col
);
    assign fetch_col = col_rev ? ~scan_col : scan_col;
endmodule

// File: rtl/gsr_pix_path.sv
module gsr_pix_path
    import gsr_pkg::*;
#(
    parameter int GS_W = 4,
    parameter int NPIX = 2
) (
    input  logic [NPIX*GS_W-1:0]       ram_byte,
    input  logic                       nib_swap,
    input  disp_mode_e                 mode,
    output logic [NPIX-1:0][GS_W-1:0]  pix
);
    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        logic [GS_W-1:0] raw;
        logic [GS_W-1:0] sel;
        assign raw = ram_byte[(NPIX-1-i)*GS_W +: GS_W];
        assign sel = nib_swap ? ram_byte[i*GS_W +: GS_W] : raw;
        assign pix[i] = mode_apply(sel, mode);
    end
endmodule

// File: rtl/gsr_top.sv
module gsr_top
    import gsr_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int COL_W = 6,
    parameter int GS_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_vld,
    input  logic [ROW_W-1:0] scan_row,
    input  logic [COL_W-1:0] scan_col,
    input  logic [2*GS_W-1:0] ram_byte,
    input  logic             col_rev,
    input  logic             nib_swap,
    input  logic             com_rev,
    input  logic             com_split,
    input  logic [ROW_W-1:0] start_line,
    input  logic [ROW_W-1:0] com_offset,
    input  logic [ROW_W-1:0] mux_ratio,
    input  logic [1:0]       disp_mode,
    input  logic             sleep_en,
    output logic [ROW_W-1:0] fetch_row,
    output logic [COL_W-1:0] fetch_col,
    output logic [ROW_W-1:0] com_idx,
    output logic             drive_en,
    output logic [GS_W-1:0]  pix_left,
    output logic [GS_W-1:0]  pix_right
);
    localparam int NPIX = 2;
    localparam logic [GS_W-1:0] GS_MAX = {GS_W{1'b1}};

    remap_t                    rm;
    disp_mode_e                mode;
    logic [ROW_W-1:0]          com_next;
    logic [NPIX-1:0][GS_W-1:0] pix_c;
    logic                      row_live;

    assign rm   = '{col_rev: col_rev, nib_swap: nib_swap, com_rev: com_rev, com_split: com_split};
    assign mode = disp_mode_e'(disp_mode);
    assign row_live = scan_vld && !sleep_en && (scan_row <= mux_ratio);

    gsr_row_map #(.ROW_W(ROW_W)) u_row (
        .scan_row   (scan_row),
        .start_line (start_line),
        .com_offset (com_offset),
        .com_rev    (rm.com_rev),
        .com_split  (rm.com_split),
        .fetch_row  (fetch_row),
        .com_next   (com_next)
    );

    gsr_col_map #(.COL_W(COL_W)) u_col (
        .scan_col  (scan_col),
        .col_rev   (rm.col_rev),
        .fetch_col (fetch_col)
    );

    gsr_pix_path #(.GS_W(GS_W), .NPIX(NPIX)) u_pix (
        .ram_byte (ram_byte),
        .nib_swap (rm.nib_swap),
        .mode     (mode),
        .pix      (pix_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_en  <= 1'b0;
            com_idx   <= '0;
            pix_left  <= '0;
            pix_right <= '0;
        end else begin
            drive_en  <= row_live;
            if (scan_vld) com_idx <= com_next;
            pix_left  <= row_live ? pix_c[0] : '0;
            pix_right <= row_live ? pix_c[1] : '0;
        end
    end

    // R10
    sleep_blank_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_en |=> (!drive_en && pix_left == '0 && pix_right == '0));

    // R6
    mux_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_vld && scan_row > mux_ratio) |=> !drive_en);

    // R7
    all_on_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_en == 1'b0 || drive_en == 1'b1) && scan_vld && !sleep_en
        && scan_row <= mux_ratio && disp_mode == 2'b01
        |=> (drive_en && pix_left == GS_MAX && pix_right == GS_MAX));

    // R8
    all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_mode == 2'b10) |=> (pix_left == '0 && pix_right == '0));

    // R9
    invert_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_vld && !sleep_en && scan_row <= mux_ratio && disp_mode == 2'b11 && !nib_swap)
        |=> (pix_left == GS_MAX - $past(ram_byte[2*GS_W-1:GS_W])));

    // R4
    com_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_vld && !com_rev && !com_split)
        |=> (com_idx == ROW_W'($past(scan_row) + $past(com_offset))));

endmodule

// File: tb/tb_gsr_top.sv
`timescale 1ns/100ps
module tb_gsr_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       scan_vld;
    logic [6:0] scan_row;
    logic [5:0] scan_col;
    logic [7:0] ram_byte;
    logic       col_rev, nib_swap, com_rev, com_split;
    logic [6:0] start_line, com_offset, mux_ratio;
    logic [1:0] disp_mode;
    logic       sleep_en;
    logic [6:0] fetch_row;
    logic [5:0] fetch_col;
    logic [6:0] com_idx;
    logic       drive_en;
    logic [3:0] pix_left, pix_right;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gsr_top dut (
        .clk(clk), .rst(rst), .scan_vld(scan_vld), .scan_row(scan_row),
        .scan_col(scan_col), .ram_byte(ram_byte), .col_rev(col_rev),
        .nib_swap(nib_swap), .com_rev(com_rev), .com_split(com_split),
        .start_line(start_line), .com_offset(com_offset), .mux_ratio(mux_ratio),
        .disp_mode(disp_mode), .sleep_en(sleep_en), .fetch_row(fetch_row),
        .fetch_col(fetch_col), .com_idx(com_idx), .drive_en(drive_en),
        .pix_left(pix_left), .pix_right(pix_right)
    );

    // flg = {sleep, split, comrev, colrev, swap}
    typedef struct packed {
        logic [6:0] row;
        logic [5:0] col;
        logic [6:0] start;
        logic [6:0] off;
        logic [7:0] data;
        logic [1:0] mode;
        logic [4:0] flg;
        logic [6:0] mux;
        logic [6:0] e_frow;
        logic [5:0] e_fcol;
        logic [6:0] e_com;
        logic       e_en;
        logic [3:0] e_pa;
        logic [3:0] e_pb;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{7'd5,   6'd10, 7'd0,   7'd0,  8'hA3, 2'd0, 5'b00000, 7'd127, 7'd5,   6'd10, 7'd5,   1'b1, 4'hA, 4'h3},
        '{7'd100, 6'd0,  7'd40,  7'd30, 8'h3C, 2'd0, 5'b00001, 7'd127, 7'd12,  6'd0,  7'd2,   1'b1, 4'hC, 4'h3},
        '{7'd7,   6'd5,  7'd3,   7'd0,  8'h12, 2'd3, 5'b00010, 7'd127, 7'd10,  6'd58, 7'd7,   1'b1, 4'hE, 4'hD},
        '{7'd0,   6'd63, 7'd127, 7'd0,  8'h5F, 2'd1, 5'b00100, 7'd127, 7'd127, 6'd63, 7'd127, 1'b1, 4'hF, 4'hF},
        '{7'd20,  6'd1,  7'd0,   7'd10, 8'hFF, 2'd2, 5'b00100, 7'd127, 7'd20,  6'd1,  7'd97,  1'b1, 4'h0, 4'h0},
        '{7'd3,   6'd2,  7'd0,   7'd0,  8'h48, 2'd0, 5'b01000, 7'd127, 7'd3,   6'd2,  7'd6,   1'b1, 4'h4, 4'h8},
        '{7'd70,  6'd0,  7'd0,   7'd0,  8'h77, 2'd0, 5'b01000, 7'd127, 7'd70,  6'd0,  7'd13,  1'b1, 4'h7, 4'h7},
        '{7'd70,  6'd0,  7'd0,   7'd0,  8'h77, 2'd0, 5'b00000, 7'd63,  7'd70,  6'd0,  7'd70,  1'b0, 4'h0, 4'h0},
        '{7'd63,  6'd0,  7'd0,   7'd0,  8'h91, 2'd0, 5'b00000, 7'd63,  7'd63,  6'd0,  7'd63,  1'b1, 4'h9, 4'h1},
        '{7'd1,   6'd0,  7'd0,   7'd0,  8'hAB, 2'd0, 5'b10000, 7'd127, 7'd1,   6'd0,  7'd1,   1'b0, 4'h0, 4'h0},
        '{7'd1,   6'd0,  7'd0,   7'd0,  8'h00, 2'd3, 5'b01100, 7'd127, 7'd1,   6'd0,  7'd125, 1'b1, 4'hF, 4'hF},
        '{7'd2,   6'd3,  7'd0,   7'd0,  8'h5C, 2'd3, 5'b00011, 7'd127, 7'd2,   6'd60, 7'd2,   1'b1, 4'h3, 4'hA}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        scan_vld   = 1'b1;
        scan_row   = v.row;
        scan_col   = v.col;
        start_line = v.start;
        com_offset = v.off;
        ram_byte   = v.data;
        disp_mode  = v.mode;
        {sleep_en, com_split, com_rev, col_rev, nib_swap} = v.flg;
        mux_ratio  = v.mux;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        scan_vld = 1'b0; scan_row = '0; scan_col = '0; ram_byte = 8'hFF;
        col_rev = 1'b0; nib_swap = 1'b0; com_rev = 1'b0; com_split = 1'b0;
        start_line = '0; com_offset = '0; mux_ratio = 7'd127;
        disp_mode = 2'd1; sleep_en = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 drive_en", drive_en, 0);
        chk("R11 com_idx", com_idx, 0);
        chk("R11 pix_left", pix_left, 0);
        chk("R11 pix_right", pix_right, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            #1;
            chk("R1 fetch_row", fetch_row, VECS[i].e_frow);
            chk("R2 fetch_col", fetch_col, VECS[i].e_fcol);
            @(posedge clk);
            @(negedge clk);
            chk("R4/R5 com_idx", com_idx, VECS[i].e_com);
            chk("R6/R10 drive_en", drive_en, VECS[i].e_en);
            chk("R3/R7/R8/R9 pix_left", pix_left, VECS[i].e_pa);
            chk("R3/R7/R8/R9 pix_right", pix_right, VECS[i].e_pb);
        end

        // R6: no valid scan -> not driven, pixels blank, com held
        scan_vld = 1'b0; scan_row = 7'd9; disp_mode = 2'd1; sleep_en = 1'b0;
        com_rev = 1'b0; com_split = 1'b0; com_offset = 7'd0;
        @(posedge clk); @(negedge clk);
        chk("R6 idle drive_en", drive_en, 0);
        chk("R6 idle pix_left", pix_left, 0);
        chk("R4 com held", com_idx, 2);

        // R10: sleep then wake with all-on
        scan_vld = 1'b1; sleep_en = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 sleep drive_en", drive_en, 0);
        chk("R10 sleep pix_right", pix_right, 0);
        sleep_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 wake drive_en", drive_en, 1);
        chk("R7 wake pix_right", pix_right, 15);

        // R8 all off with bright data
        disp_mode = 2'd2; ram_byte = 8'hEE;
        @(posedge clk); @(negedge clk);
        chk("R8 pix_left", pix_left, 0);
        chk("R8 drive_en", drive_en, 1);

        // R1 wrap at maximum sum
        scan_row = 7'd127; start_line = 7'd127; #1;
        chk("R1 wrap", fetch_row, 126);

        // R11 mid-run reset
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R11 rerun drive_en", drive_en, 0);
        chk("R11 rerun com_idx", com_idx, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule